// File: doc/BRIEF.md
# Weakly Consistent Replicated Memory

This block models a small multi-node shared memory that follows a weak ordering discipline. Each of `NODES` processor ports owns a private copy of a small address space. The ports share one global memory array. Each node has two bounded queues. An outbound queue holds that node's pending writes. An inbound queue holds pending updates waiting to be written into the node's local copy.

A processor write only enqueues. Background steps then run without any request from outside. A round-robin arbiter moves one queued write per cycle into global memory and broadcasts it to every node's inbound queue. Each broadcast entry carries a flag that marks the copy sent back to the writer. Every node retires one inbound entry per cycle into its local copy, and all nodes can do this in the same cycle. A read that misses in the local copy triggers a fetch of the global value into the inbound queue.

Reads wait until the node's own writes have landed locally. A sync request waits until both of the node's queues are empty.

Each port takes requests on a valid/ready handshake. A request is accepted on a clock edge where both valid and ready are high. While ready is low the requester holds valid, op, address and data stable. A stalled read or sync may be withdrawn without side effects, except that a fetch may already have been queued for the read. Read results come back as a one-cycle done pulse with data. There is no back-pressure on results.

Top module: `wcm_system`

## Requirements
- R1: After reset both queues of every node are empty and every local and global location is invalid. A read therefore stalls, while sync, write and invalidate requests are ready.
- R2: The op code is 2 bits: 0 write, 1 read, 2 invalidate, 3 sync. A write is ready whenever its outbound queue (depth `QDEPTH`) is not full. An accepted write only enqueues and never overflows a queue.
- R3: A drained write updates global memory and reaches every node's local copy. A read on any node then completes with no wait.
- R4: A read completes only when the node's outbound queue is empty and its inbound queue holds no entry flagged as its own write. The read then returns the node's latest write to that address.
- R5: A read of a location that is invalid both locally and globally stalls indefinitely and produces no done pulse.
- R6: A read that misses locally, while global memory is valid, fetches the global value into the inbound queue once, and then completes with that value.
- R7: An invalidate is accepted without waiting and returns the addressed local location to invalid. A following read must then refetch and takes at least two extra cycles.
- R8: A sync request is ready only when both queues of its node are empty.
- R9: At most one write drains per cycle. Nodes with pending writes are served round-robin, starting after the last node served; after reset node 0 is first. No write drains while any inbound queue is full.
- R10: An accepted read raises `rd_done` for exactly the next cycle, with the local value at acceptance on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NODES | Per-node request valid |
| req_op | input | 2*NODES | Per-node op code (0 write, 1 read, 2 invalidate, 3 sync) |
| req_addr | input | ADDR_W*NODES | Per-node address |
| req_data | input | DATA_W*NODES | Per-node write data |
| req_ready | output | NODES | Per-node request ready |
| rd_done | output | NODES | One-cycle read completion pulse |
| rd_data | output | DATA_W*NODES | Read data, valid with rd_done |

## Verification
A corrupted own-write flag or a stuck queue count appears at the port as a read that never becomes ready, or as a sync that never becomes ready. Either shows within a few cycles of the write. A wrong arbitration pointer changes which value survives when several nodes write the same address together. That shows on the next read of that address. A local copy that is not updated, or not invalidated, shows as stale read data or as the wrong read latency after an invalidate. The scoreboard measures both.

// File: rtl/wcm_pkg.sv
package wcm_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_INVAL = 2'd2,
    OP_SYNC  = 2'd3
  } wcm_op_e;
endpackage

// File: rtl/wcm_fifo.sv
module wcm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [W-1:0]       push_data,
  input  logic               pop,
  output logic [W-1:0]       head,
  output logic               empty,
  output logic               full,
  output logic [DEPTH-1:0]   slot_live,
  output logic [DEPTH*W-1:0] slots
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [PW:0]   count;
  logic          do_pop;

  assign empty  = (count == '0);
  assign full   = (count == (PW+1)'(DEPTH));
  assign head   = mem[rd_ptr];
  assign do_pop = pop && !empty;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [PW-1:0] off;
    assign off                = PW'(k) - rd_ptr;
    assign slot_live[k]       = ({1'b0, off} < count);
    assign slots[k*W +: W]    = mem[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (PW+1)'(push && !full) - (PW+1)'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("queue overflow"); // R2
endmodule

// File: rtl/wcm_rr_arb.sv
module wcm_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last, nxt;

  always_comb begin
    grant = '0;
    nxt   = last;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = int'(last) + i;
      if (idx >= N) idx = idx - N;
      if (en && req[idx] && (grant == '0)) begin
        grant[idx] = 1'b1;
        nxt        = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last <= IW'(N-1);
    else        last <= nxt;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("multiple grants"); // R9
  AST_GRANT_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((grant & req) != '0)) else $error("grant without request"); // R9
endmodule

// File: rtl/wcm_node.sv
module wcm_node
  import wcm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_data,
  output logic                     req_ready,
  output logic                     rd_done,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     oq_nonempty,
  output logic [ADDR_W+DATA_W-1:0] oq_head,
  input  logic                     oq_pop,
  output logic                     iq_full,
  input  logic                     bc_push,
  input  logic [ADDR_W+DATA_W:0]   bc_entry,
  input  logic                     gl_valid,
  input  logic [DATA_W-1:0]        gl_data
);
  localparam int LINES = 1 << ADDR_W;
  localparam int OQW   = ADDR_W + DATA_W;
  localparam int IQW   = OQW + 1;

  logic              loc_valid [LINES];
  logic [DATA_W-1:0] loc_data  [LINES];

  logic oq_empty, oq_full, iq_empty;
  logic [QDEPTH-1:0]     oq_live, iq_live;
  logic [QDEPTH*OQW-1:0] oq_slots;
  logic [QDEPTH*IQW-1:0] iq_slots;
  logic [IQW-1:0]        iq_head, iq_in;
  logic own_pending, fetch_match, fetch, iq_push;
  logic is_wr, is_rd, is_inv, is_sync, acc;

  assign is_wr   = req_valid && (req_op == OP_WRITE);
  assign is_rd   = req_valid && (req_op == OP_READ);
  assign is_inv  = req_valid && (req_op == OP_INVAL);
  assign is_sync = req_valid && (req_op == OP_SYNC);

  wcm_fifo #(.W(OQW), .DEPTH(QDEPTH)) u_outq (
    .clk, .rst_n,
    .push(is_wr && !oq_full), .push_data({req_addr, req_data}),
    .pop(oq_pop), .head(oq_head), .empty(oq_empty), .full(oq_full),
    .slot_live(oq_live), .slots(oq_slots)
  );

  assign iq_in   = bc_push ? bc_entry : {req_addr, gl_data, 1'b0};
  assign iq_push = bc_push || fetch;

  wcm_fifo #(.W(IQW), .DEPTH(QDEPTH)) u_inq (
    .clk, .rst_n,
    .push(iq_push), .push_data(iq_in),
    .pop(!iq_empty), .head(iq_head), .empty(iq_empty), .full(iq_full),
    .slot_live(iq_live), .slots(iq_slots)
  );

  assign oq_nonempty = !oq_empty;

  always_comb begin
    own_pending = 1'b0;
    fetch_match = 1'b0;
    for (int k = 0; k < QDEPTH; k++) begin
      if (iq_live[k] && iq_slots[k*IQW]) own_pending = 1'b1;
      if (iq_live[k] && (iq_slots[k*IQW+1 +: OQW] == {req_addr, gl_data}))
        fetch_match = 1'b1;
    end
  end

  assign fetch = is_rd && !loc_valid[req_addr] && gl_valid && !fetch_match
                 && !bc_push && !iq_full;

  always_comb begin
    case (req_op)
      OP_WRITE: req_ready = !oq_full;
      OP_READ:  req_ready = oq_empty && !own_pending && loc_valid[req_addr];
      OP_INVAL: req_ready = 1'b1;
      default:  req_ready = oq_empty && iq_empty;
    endcase
  end

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LINES; k++) loc_valid[k] <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_done <= acc && is_rd;
      if (acc && is_rd) rd_data <= loc_data[req_addr];
      if (acc && is_inv) loc_valid[req_addr] <= 1'b0;
      if (!iq_empty) begin
        loc_valid[iq_head[IQW-1 -: ADDR_W]] <= 1'b1;
        loc_data[iq_head[IQW-1 -: ADDR_W]]  <= iq_head[DATA_W:1];
      end
    end
  end

  AST_RD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_rd) |-> (oq_empty && !own_pending)) else $error("read out of order"); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_rd) |=> rd_done) else $error("missing done"); // R10
  AST_SYNC_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_sync) |-> (oq_empty && iq_empty)) else $error("sync early"); // R8
  AST_FETCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> (!fetch || !$stable(req_addr))) else $error("repeated fetch"); // R6
endmodule

// File: rtl/wcm_system.sv
module wcm_system #(
  parameter int NODES  = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int QDEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NODES-1:0]         req_valid,
  input  logic [2*NODES-1:0]       req_op,
  input  logic [ADDR_W*NODES-1:0]  req_addr,
  input  logic [DATA_W*NODES-1:0]  req_data,
  output logic [NODES-1:0]         req_ready,
  output logic [NODES-1:0]         rd_done,
  output logic [DATA_W*NODES-1:0]  rd_data
);
  localparam int LINES = 1 << ADDR_W;
  localparam int OQW   = ADDR_W + DATA_W;

  logic              gl_valid [LINES];
  logic [DATA_W-1:0] gl_data  [LINES];

  logic [NODES-1:0]     oq_nonempty, iq_full, grant;
  logic [OQW-1:0]       oq_head [NODES];
  logic                 bc_push;
  logic [ADDR_W-1:0]    g_addr;
  logic [DATA_W-1:0]    g_data;

  wcm_rr_arb #(.N(NODES)) u_arb (
    .clk, .rst_n, .en(iq_full == '0), .req(oq_nonempty), .grant(grant)
  );

  assign bc_push = (grant != '0);

  always_comb begin
    g_addr = '0;
    g_data = '0;
    for (int k = 0; k < NODES; k++) begin
      if (grant[k]) begin
        g_addr = oq_head[k][OQW-1 -: ADDR_W];
        g_data = oq_head[k][DATA_W-1:0];
      end
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [ADDR_W-1:0] a_n;
    assign a_n = req_addr[n*ADDR_W +: ADDR_W];
    wcm_node #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_node (
      .clk, .rst_n,
      .req_valid(req_valid[n]), .req_op(req_op[2*n +: 2]),
      .req_addr(a_n), .req_data(req_data[n*DATA_W +: DATA_W]),
      .req_ready(req_ready[n]), .rd_done(rd_done[n]),
      .rd_data(rd_data[n*DATA_W +: DATA_W]),
      .oq_nonempty(oq_nonempty[n]), .oq_head(oq_head[n]), .oq_pop(grant[n]),
      .iq_full(iq_full[n]), .bc_push(bc_push),
      .bc_entry({g_addr, g_data, grant[n]}),
      .gl_valid(gl_valid[a_n]), .gl_data(gl_data[a_n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LINES; k++) gl_valid[k] <= 1'b0;
    end else if (bc_push) begin
      gl_valid[g_addr] <= 1'b1;
      gl_data[g_addr]  <= g_data;
    end
  end

  AST_GLOBAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bc_push |=> (gl_valid[$past(g_addr)] && (gl_data[$past(g_addr)] == $past(g_data))))
    else $error("global write lost"); // R3
endmodule

// File: tb/wcm_system_test.sv
module wcm_system_test;
  localparam int N = 3, AW = 2, DW = 8, QD = 4;
  localparam logic [1:0] WR = 2'd0, RD = 2'd1, INV = 2'd2, SYN = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]    rv = '0;
  logic [2*N-1:0]  rop = '0;
  logic [AW*N-1:0] ra = '0;
  logic [DW*N-1:0] rdat = '0;
  logic [N-1:0]    rdy, done;
  logic [DW*N-1:0] rdout;

  int checks = 0, errors = 0, cyc = 0;
  int exp_node[$];
  int exp_data[$];

  always #10 clk = ~clk;

  wcm_system #(.NODES(N), .ADDR_W(AW), .DATA_W(DW), .QDEPTH(QD)) uut (
    .clk, .rst_n, .req_valid(rv), .req_op(rop), .req_addr(ra), .req_data(rdat),
    .req_ready(rdy), .rd_done(done), .rd_data(rdout)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    for (int n = 0; n < N; n++) begin
      if (rst_n && done[n]) begin
        if (exp_node.size() == 0) begin
          chk(0, "R10 unexpected done", n, -1);
        end else begin
          int en, ed;
          en = exp_node.pop_front();
          ed = exp_data.pop_front();
          chk(en == n, "R10 done node", n, en);
          chk(int'(rdout[n*DW +: DW]) == ed, "R4 read data", int'(rdout[n*DW +: DW]), ed);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      finish_run();
    end
  end

  task automatic drive(int n, logic [1:0] op, int a, int d);
    rv[n] = 1'b1;
    rop[2*n +: 2] = op;
    ra[n*AW +: AW] = AW'(a);
    rdat[n*DW +: DW] = DW'(d);
  endtask

  // issue one request, counting the cycles it waits; optional expected read data
  task automatic issue(int n, logic [1:0] op, int a, int d, int exp, output int waits);
    waits = 0;
    drive(n, op, a, d);
    #1;
    while (!rdy[n]) begin
      @(negedge clk);
      waits++;
      #1;
    end
    if (op == RD) begin
      exp_node.push_back(n);
      exp_data.push_back(exp);
    end
    @(negedge clk);
    rv[n] = 1'b0;
  endtask

  task automatic settle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    drive(0, SYN, 0, 0); #1;
    chk(rdy[0], "R1 sync ready after reset", rdy[0], 1);
    drive(0, WR, 0, 0); #1;
    chk(rdy[0], "R1 write ready after reset", rdy[0], 1);
    drive(0, RD, 0, 0);
    settle(4); #1;
    chk(!rdy[0] && done == '0, "R1 read stalls after reset", rdy[0], 0);
    rv[0] = 1'b0;
    settle(1);

    // R4: read right after own write waits for the own update
    issue(0, WR, 1, 8'hA5, 0, w);
    issue(0, RD, 1, 0, 8'hA5, w);
    chk(w >= 1, "R4 read stalled behind own write", w, 1);
    settle(1);

    // R3 / R10: broadcast reached the other nodes, zero-wait reads
    issue(1, RD, 1, 0, 8'hA5, w);
    chk(w == 0, "R3 node1 read without wait", w, 0);
    issue(2, RD, 1, 0, 8'hA5, w);
    chk(w == 0, "R10 node2 read latency", w, 0);
    settle(1);

    // R5: location never written stays stalled
    drive(1, RD, 2, 0);
    settle(6); #1;
    chk(!rdy[1], "R5 null read stalls", rdy[1], 0);
    rv[1] = 1'b0;
    settle(1);

    // R7 / R6: invalidate then refetch from global memory
    issue(1, INV, 1, 0, 0, w);
    chk(w == 0, "R7 invalidate accepted at once", w, 0);
    issue(1, RD, 1, 0, 8'hA5, w);
    chk(w >= 2, "R6 refetch latency", w, 2);
    settle(1);

    // R8: sync waits for the queues to drain
    issue(2, WR, 0, 8'h44, 0, w);
    issue(2, SYN, 0, 0, 0, w);
    chk(w >= 1, "R8 sync waited for drain", w, 1);
    issue(0, RD, 0, 0, 8'h44, w);
    chk(w == 0, "R8 data visible after sync", w, 0);

    // R9: round-robin order; last served node is 2 here, so node 1 alone first
    issue(1, WR, 2, 8'h11, 0, w);
    settle(4);
    drive(0, WR, 3, 8'h30);
    drive(1, WR, 3, 8'h31);
    drive(2, WR, 3, 8'h32);
    #1;
    chk(rdy == '1, "R2 writes ready together", int'(rdy), 7);
    @(negedge clk);
    rv = '0;
    issue(0, SYN, 0, 0, 0, w);
    settle(4);
    // order after node 1: 2, 0, 1 -> node 1 data survives
    issue(2, RD, 3, 0, 8'h31, w);
    issue(0, RD, 2, 0, 8'h11, w);
    chk(w == 0, "R9 earlier single write visible", w, 0);

    settle(3);
    chk(exp_node.size() == 0, "R10 all reads completed", exp_node.size(), 0);
    finish_run();
  end
endmodule